// File: doc/BRIEF.md
# Cascadable Four-Bit Magnitude Comparator Stage

This block is a purely combinational comparator for two unsigned words of four bits, `aWord` and `bWord`, where bit 3 carries the most weight. It drives three result lines: greater, equal and less. It also takes three cascade lines that describe how the less significant part of a wider comparison came out.

The scan starts at the top bit. The first bit position where the words disagree settles the result by itself. When all bit pairs match, the cascade lines decide. Normal cascade patterns give one-hot results. Abnormal cascade patterns also have defined results, and these results may be non-exclusive.

Wider comparisons can be built in two ways. In a chain, each stage's three outputs feed the cascade inputs of the next more significant stage, and the lowest stage has its cascade tied to greater-low, equal-high, less-low. In a parallel tree, a leaf stage can use the greater and less cascade lines as a fifth bit pair with the equal cascade line held low.

Top module: `magcmp_stage`

## Requirements
- R1: When `aWord` and `bWord` differ, `outGt` is high exactly when `aWord` is the larger unsigned value, and `outLt` is high exactly when it is the smaller one. The decision comes from the most significant differing bit (bit 3 first).
- R2: When the words differ, exactly one of `outGt`/`outLt` is high, `outEq` is low, and the three cascade inputs have no effect on any output.
- R3: When the words are equal and `cascEq` is high, the outputs are `outEq`=1, `outGt`=0, `outLt`=0, whatever `cascGt` and `cascLt` are.
- R4: When the words are equal and `cascEq` is low, a lone high `cascGt` gives `outGt`=1, `outEq`=0, `outLt`=0. A lone high `cascLt` gives the mirror result, with `outLt`=1 and the other two outputs low.
- R5: When the words are equal, `cascEq` is low, and both `cascGt` and `cascLt` are high, all three outputs are low.
- R6: When the words are equal and all three cascade inputs are low, `outGt` and `outLt` are both high and `outEq` is low.
- R7: Two stages in series, where the low stage has its cascade tied to (gt, eq, lt) = (0, 1, 0) and its outputs feed the high stage's cascade, compare 8-bit unsigned words correctly with one-hot results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aWord | input | 4 | First operand, bit 3 most significant |
| bWord | input | 4 | Second operand, bit 3 most significant |
| cascGt | input | 1 | Cascade: lower part found A greater |
| cascEq | input | 1 | Cascade: lower part found equal |
| cascLt | input | 1 | Cascade: lower part found A less |
| outGt | output | 1 | Result: A greater |
| outEq | output | 1 | Result: equal |
| outLt | output | 1 | Result: A less |

## Verification
Every one of the 2048 combinations of both words and the three cascade lines is applied to one stage. Each result is compared against an integer magnitude model. Pairs that differ in a single low bit while sharing the upper bits show whether bit priority is right. Equal pairs under all eight cascade patterns separate the one-hot, all-low and both-high results. A two-stage chain is then driven with a grid of 8-bit operand pairs, which shows whether the results from the low stage pass correctly through the cascade inputs.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Three-line comparison result, used both for cascade input and stage output
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpFlags_t;

  // Per-bit strobes from the datapath to the resolver
  typedef struct packed {
    logic [3:0] aAbove;
    logic [3:0] bAbove;
  } bitStrobes_t;

endpackage

// File: rtl/magcmp_bitdiff.sv
module magcmp_bitdiff
  import magcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] aWord,
  input  logic [WIDTH-1:0] bWord,
  output logic [WIDTH-1:0] aAbove,
  output logic [WIDTH-1:0] bAbove
);

  // One pair of strobes per bit position
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign aAbove[i] = aWord[i] & ~bWord[i];
    assign bAbove[i] = ~aWord[i] & bWord[i];
  end

endmodule

// File: rtl/magcmp_resolve.sv
module magcmp_resolve
  import magcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] aAbove,
  input  logic [WIDTH-1:0] bAbove,
  input  cmpFlags_t        cascIn,
  output cmpFlags_t        result
);

  localparam int MSB = WIDTH - 1;

  logic decided;
  logic aWins;

  // Scan from the top bit down; the first differing position decides
  always_comb begin
    decided = 1'b0;
    aWins   = 1'b0;
    for (int i = MSB; i >= 0; i--) begin
      if (!decided && (aAbove[i] || bAbove[i])) begin
        decided = 1'b1;
        aWins   = aAbove[i];
      end
    end
  end

  always_comb begin
    if (decided) begin
      result.gt = aWins;
      result.lt = ~aWins;
      result.eq = 1'b0;
    end else begin
      // Equal words: the cascade lines set the result, abnormal patterns included
      result.eq = cascIn.eq;
      result.gt = ~cascIn.eq & ~cascIn.lt;
      result.lt = ~cascIn.eq & ~cascIn.gt;
    end
  end

  // Checks next to the resolver
  always_comb begin
    if (!$isunknown({aAbove, bAbove, cascIn})) begin
      // R1: the top differing bit alone picks the winner
      if (aAbove[MSB] || bAbove[MSB])
        a_r1_msb_priority: assert (result.gt == aAbove[MSB] && result.lt == bAbove[MSB]);
      // R2: any differing bit gives a one-hot, non-equal result
      if (|(aAbove | bAbove))
        a_r2_diff_onehot: assert (!result.eq && (result.gt ^ result.lt));
      // R3: equal words with equal cascade give equal only
      if (!(|(aAbove | bAbove)) && cascIn.eq)
        a_r3_eq_passes: assert (result == 3'b010);
      // R5: conflicting cascade clears every output
      if (!(|(aAbove | bAbove)) && !cascIn.eq && cascIn.gt && cascIn.lt)
        a_r5_conflict_low: assert (result == 3'b000);
      // R6: silent cascade raises both magnitude outputs
      if (!(|(aAbove | bAbove)) && cascIn == 3'b000)
        a_r6_silent_both: assert (result == 3'b101);
    end
  end

endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
  import magcmp_pkg::*;
(
  input  logic [3:0] aWord,
  input  logic [3:0] bWord,
  input  logic       cascGt,
  input  logic       cascEq,
  input  logic       cascLt,
  output logic       outGt,
  output logic       outEq,
  output logic       outLt
);

  localparam int WIDTH = 4;

  bitStrobes_t strobes;
  cmpFlags_t   cascIn;
  cmpFlags_t   result;

  assign cascIn = '{gt: cascGt, eq: cascEq, lt: cascLt};

  magcmp_bitdiff #(.WIDTH(WIDTH)) u_bitdiff (
    .aWord  (aWord),
    .bWord  (bWord),
    .aAbove (strobes.aAbove),
    .bAbove (strobes.bAbove)
  );

  magcmp_resolve #(.WIDTH(WIDTH)) u_resolve (
    .aAbove (strobes.aAbove),
    .bAbove (strobes.bAbove),
    .cascIn (cascIn),
    .result (result)
  );

  assign outGt = result.gt;
  assign outEq = result.eq;
  assign outLt = result.lt;

  // R4: a lone cascade magnitude line passes straight through on equal words
  always_comb begin
    if (!$isunknown({aWord, bWord, cascGt, cascEq, cascLt}) && aWord == bWord
        && !cascEq && (cascGt ^ cascLt))
      a_r4_lone_cascade: assert (outGt == cascGt && outLt == cascLt && !outEq);
  end

endmodule

// File: tb/magcmp_stage_bench.sv
module magcmp_stage_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0] aWord, bWord;
  logic cascGt, cascEq, cascLt;
  logic outGt, outEq, outLt;

  magcmp_stage u_magcmp_stage (
    .aWord(aWord), .bWord(bWord),
    .cascGt(cascGt), .cascEq(cascEq), .cascLt(cascLt),
    .outGt(outGt), .outEq(outEq), .outLt(outLt)
  );

  // Two-stage chain for R7
  logic [7:0] wideA, wideB;
  logic loGt, loEq, loLt, hiGt, hiEq, hiLt;

  magcmp_stage u_lo (
    .aWord(wideA[3:0]), .bWord(wideB[3:0]),
    .cascGt(1'b0), .cascEq(1'b1), .cascLt(1'b0),
    .outGt(loGt), .outEq(loEq), .outLt(loLt)
  );
  magcmp_stage u_hi (
    .aWord(wideA[7:4]), .bWord(wideB[7:4]),
    .cascGt(loGt), .cascEq(loEq), .cascLt(loLt),
    .outGt(hiGt), .outEq(hiEq), .outLt(hiLt)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Behavioural model: integer magnitude first, cascade rules on equality
  function automatic logic [2:0] refModel(int a, int b, bit g, bit e, bit l);
    if (a > b) return 3'b100;
    if (a < b) return 3'b001;
    if (e) return 3'b010;
    if (g && l) return 3'b000;
    if (g) return 3'b100;
    if (l) return 3'b001;
    return 3'b101;
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got {gt,eq,lt}=%b expected %b (a=%0d b=%0d casc=%b%b%b)",
               tag, got, exp, aWord, bWord, cascGt, cascEq, cascLt);
    end
  endtask

  function automatic string tagFor(int a, int b, bit g, bit e, bit l);
    if (a != b) return "R1 R2";
    if (e) return "R3";
    if (g && l) return "R5";
    if (g || l) return "R4";
    return "R6";
  endfunction

  initial begin
    aWord = 4'd0; bWord = 4'd0;
    cascGt = 1'b0; cascEq = 1'b1; cascLt = 1'b0;
    wideA = 8'd0; wideB = 8'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: tied-off stage with equal zero words reports equal (R3)
    check("R3 reset", {outGt, outEq, outLt}, 3'b010);

    // Full sweep of one stage
    for (int v = 0; v < 2048; v++) begin
      @(posedge clk);
      aWord  = v[10:7];
      bWord  = v[6:3];
      cascGt = v[2];
      cascEq = v[1];
      cascLt = v[0];
      @(negedge clk);
      check(tagFor(v[10:7], v[6:3], v[2], v[1], v[0]), {outGt, outEq, outLt},
            refModel(v[10:7], v[6:3], v[2], v[1], v[0]));
    end

    // R1 boundary: only the top bit differs versus lower bits opposing
    @(posedge clk);
    aWord = 4'b1000; bWord = 4'b0111; cascGt = 1'b0; cascEq = 1'b0; cascLt = 1'b1;
    @(negedge clk);
    check("R1 msb wins", {outGt, outEq, outLt}, 3'b100);

    // R7: chained 8-bit comparison over a grid, plus edge pairs
    for (int x = 0; x < 256; x += 7) begin
      for (int y = 0; y < 256; y += 5) begin
        @(posedge clk);
        wideA = x[7:0]; wideB = y[7:0];
        @(negedge clk);
        check("R7 chain", {hiGt, hiEq, hiLt}, refModel(x, y, 1'b0, 1'b1, 1'b0));
      end
    end
    for (int k = 0; k < 256; k += 17) begin
      @(posedge clk);
      wideA = k[7:0]; wideB = k[7:0];
      @(negedge clk);
      check("R7 chain equal", {hiGt, hiEq, hiLt}, 3'b010);
    end
    finished = 1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          compared++;
          mismatched++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
      wait (finished);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule